// File: doc/BRIEF.md
# Sensor-Code to Millidegree Converter

This block turns a 10-bit unsigned temperature sensor reading into a signed temperature in millidegrees Celsius. It evaluates a fixed quartic with small coefficients of mixed sign. The quartic maps code 0 to -56197 mC and code 1023 to roughly 136402 mC, and it rises steadily between those two ends.

The datapath uses Horner's scheme in four pipelined multiply-add stages. Every coefficient is scaled by the same power of two, so no intermediate rescaling is needed. A fifth stage makes the only rescaling step. It rounds half away from zero and produces a 32-bit two's-complement result.

The pipeline accepts a new code on every cycle. Results leave in the order the codes arrived, each after a fixed number of cycles.

Top module: `sensor_temp_conv`

## Requirements
- R1: A code presented with `in_valid` high at a rising edge produces exactly one `out_valid` pulse, visible after the fifth rising edge that follows. A cycle without `in_valid` produces no `out_valid` at the matching output cycle.
- R2: Codes may arrive on consecutive cycles without gaps. Results come out in the same order as the codes.
- R3: For every code from 0 to 1023, `out_temp` (signed) lies within ±2 mC of the exact real-valued polynomial T(N) = -3.4627e-8·N⁴ + 1.1023e-4·N³ - 0.19165·N² + 306.04·N - 56197 (mC).
- R4: Code 0 yields exactly -56197 (0xFFFF247B).
- R5: Code 1023 yields a value between 136400 and 136404.
- R6: While reset is low, and after reset until the first result, `out_valid` is 0 and `out_temp` is 0.
- R7: When `in_valid` is low, `in_code` is ignored. The result stream carries no result for that cycle, and the following results are unchanged.
- R8: While `out_valid` is low, `out_temp` holds its last value.

Top module has no back-pressure; it is always ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| in_valid | input | 1 | Qualifies in_code for this cycle |
| in_code | input | 10 | Unsigned sensor code |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_temp | output | 32 | Signed temperature in millidegrees Celsius |

## Verification
The assertions assume the following about the inputs:
- `rst_n` is released synchronously to the clock.
- `in_valid` and `in_code` are 0/1 values with no unknown bits.
- Codes fall in 0 to 1023, which the port width enforces.

Because of these assumptions, the result range and the latency relation can be stated without conditions beyond reset. The stimulus drives inputs only at the falling edge. It holds `in_valid` low during reset, then mixes three kinds of traffic: directed endpoint codes, a gapless sweep of every code, and seeded random codes with random gaps. Random codes are drawn from the full 10-bit range.

// File: rtl/tc_pkg.sv
package tc_pkg;

  // Fraction bits shared by every scaled coefficient.
  localparam int unsigned TC_FRAC   = 52;
  // Integer headroom above the fraction (sign plus magnitude of the worst partial sum).
  localparam int unsigned TC_HEAD   = 24;
  localparam int unsigned TC_ACC_W  = TC_FRAC + TC_HEAD;
  localparam int unsigned TC_STAGES = 4;

  // Round a real coefficient, in millidegrees per code power, onto the 2^TC_FRAC grid.
  function automatic logic signed [63:0] tc_scale(input real coef);
    real unit;
    unit = real'(64'sd1 <<< TC_FRAC);
    return 64'(longint'(coef * unit));
  endfunction

  // Leading (fourth-power) coefficient, seeding the Horner chain.
  localparam logic signed [TC_ACC_W-1:0] TC_LEAD =
    TC_ACC_W'(tc_scale(-34627.0e-12));

  // Constant term: integer millidegrees placed above the fraction.
  localparam logic signed [TC_ACC_W-1:0] TC_BASE =
    TC_ACC_W'(-56197) <<< TC_FRAC;

  // Term added by Horner stage idx (0 = cubic term ... 3 = constant term).
  function automatic logic signed [TC_ACC_W-1:0] tc_addend(input int unsigned idx);
    case (idx)
      0:       return TC_ACC_W'(tc_scale(110230.0e-9));
      1:       return TC_ACC_W'(tc_scale(-191650.0e-6));
      2:       return TC_ACC_W'(tc_scale(306040.0e-3));
      default: return TC_BASE;
    endcase
  endfunction

endpackage

// File: rtl/tc_horner_stage.sv
module tc_horner_stage #(
  parameter int unsigned CODE_W = 10,
  parameter int unsigned ACC_W  = 76,
  parameter logic signed [ACC_W-1:0] ADDEND = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic [CODE_W-1:0]       in_code,
  input  logic signed [ACC_W-1:0] in_acc,
  output logic                    out_vld,
  output logic [CODE_W-1:0]       out_code,
  output logic signed [ACC_W-1:0] out_acc
);

  localparam int unsigned PROD_W = ACC_W + CODE_W + 1;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc_d;
  logic                     ld_en;

  // Multiply-add; the value always fits ACC_W, so the upper product bits are dropped.
  always_comb begin
    prod  = PROD_W'(in_acc) * PROD_W'($signed({1'b0, in_code}));
    acc_d = $signed(prod[ACC_W-1:0]) + ADDEND;
    ld_en = in_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_code <= '0;
      out_acc  <= '0;
    end else if (ld_en) begin
      out_code <= in_code;
      out_acc  <= acc_d;
    end
  end

endmodule

// File: rtl/tc_round_out.sv
module tc_round_out #(
  parameter int unsigned ACC_W = 76,
  parameter int unsigned FRAC  = 52,
  parameter int unsigned OUT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic signed [ACC_W-1:0] in_acc,
  output logic                    out_vld,
  output logic [OUT_W-1:0]        out_val
);

  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC - 1);

  logic             neg;
  logic [ACC_W-1:0] mag;
  logic [ACC_W-1:0] rnd;
  logic [ACC_W-1:0] res;
  logic             ld_en;

  // Round half away from zero: round the magnitude up at the half, then restore the sign.
  always_comb begin
    neg   = in_acc[ACC_W-1];
    mag   = neg ? ACC_W'(-in_acc) : ACC_W'(in_acc);
    rnd   = (mag + HALF) >> FRAC;
    res   = neg ? (~rnd + ACC_W'(1)) : rnd;
    ld_en = in_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_val <= '0;
    end else if (ld_en) begin
      out_val <= res[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/sensor_temp_conv.sv
module sensor_temp_conv
  import tc_pkg::*;
#(
  parameter int unsigned CODE_W = 10,
  parameter int unsigned OUT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_temp
);

  localparam int unsigned ACC_W = TC_ACC_W;
  localparam int unsigned NST   = TC_STAGES;

  logic                    vld  [NST+1];
  logic [CODE_W-1:0]       code [NST+1];
  logic signed [ACC_W-1:0] acc  [NST+1];

  always_comb begin
    vld[0]  = in_valid;
    code[0] = in_code;
    acc[0]  = TC_LEAD;
  end

  for (genvar g = 0; g < NST; g++) begin : g_horner
    tc_horner_stage #(
      .CODE_W (CODE_W),
      .ACC_W  (ACC_W),
      .ADDEND (tc_addend(g))
    ) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (vld[g]),
      .in_code  (code[g]),
      .in_acc   (acc[g]),
      .out_vld  (vld[g+1]),
      .out_code (code[g+1]),
      .out_acc  (acc[g+1])
    );
  end

  tc_round_out #(
    .ACC_W (ACC_W),
    .FRAC  (TC_FRAC),
    .OUT_W (OUT_W)
  ) u_round (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (vld[NST]),
    .in_acc  (acc[NST]),
    .out_vld (out_valid),
    .out_val (out_temp)
  );

endmodule

// File: rtl/tc_conv_checker.sv
module tc_conv_checker #(
  parameter int unsigned CODE_W = 10,
  parameter int unsigned OUT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [CODE_W-1:0] in_code,
  input logic              out_valid,
  input logic [OUT_W-1:0]  out_temp
);

  localparam int unsigned LAT = 5;

  logic [2:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
    end else if (since_rst < 3'(LAT)) begin
      since_rst <= since_rst + 3'd1;
    end
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'(LAT)) |-> (out_valid == $past(in_valid, 5)));

  assert_zero_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst >= 3'(LAT)) && $past(in_valid && (in_code == '0), 5))
      |-> (out_temp == OUT_W'(-56197)));

  assert_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (($signed(out_temp) >= -56199) && ($signed(out_temp) <= 136404)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_temp));

endmodule

bind sensor_temp_conv tc_conv_checker #(
  .CODE_W (CODE_W),
  .OUT_W  (OUT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_code   (in_code),
  .out_valid (out_valid),
  .out_temp  (out_temp)
);

// File: tb/sensor_temp_conv_tb.sv
module sensor_temp_conv_tb;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [9:0]  in_code;
  logic        out_valid;
  logic [31:0] out_temp;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit mon_en = 0;
  bit done   = 0;

  logic [9:0]  pend[$];
  logic [4:0]  vhist;
  logic [31:0] last_out;

  sensor_temp_conv u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_code   (in_code),
    .out_valid (out_valid),
    .out_temp  (out_temp)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic real model(input int n);
    real x;
    x = real'(n);
    return -34627.0e-12 * x * x * x * x + 110230.0e-9 * x * x * x
           - 191650.0e-6 * x * x + 306040.0e-3 * x - 56197.0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench-side history of accepted valids (bit 4 = five edges back).
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) vhist <= '0;
    else        vhist <= {vhist[3:0], in_valid};
  end

  always @(negedge clk) begin
    if (mon_en) begin
      // R1 / R7: a result appears exactly for each accepted cycle, never for a gap
      check(out_valid == vhist[4], "R1/R7 valid timing", int'(out_valid), int'(vhist[4]));
      if (out_valid) begin
        if (pend.size() == 0) begin
          check(1'b0, "R2 unexpected result", int'(out_temp), 0);
        end else begin
          int  c;
          real d;
          c = int'(pend.pop_front());
          d = real'($signed(out_temp)) - model(c);
          check((d <= 2.0) && (d >= -2.0), "R3 accuracy", $signed(out_temp), $rtoi(model(c)));
          if (c == 0)
            check($signed(out_temp) == -56197, "R4 code zero", $signed(out_temp), -56197);
          if (c == 1023)
            check(($signed(out_temp) >= 136400) && ($signed(out_temp) <= 136404),
                  "R5 code 1023", $signed(out_temp), 136402);
        end
        last_out = out_temp;
      end else begin
        // R8: output holds while no result is flagged
        check(out_temp == last_out, "R8 hold", $signed(out_temp), $signed(last_out));
      end
    end
  end

  task automatic send(input bit v, input logic [9:0] c);
    @(negedge clk);
    in_valid = v;
    in_code  = c;
    if (v) pend.push_back(c);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 100000);
        done = 1;
      end
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_code  = '0;
    last_out = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R6: reset state
    check(out_valid == 1'b0, "R6 reset valid", int'(out_valid), 0);
    check(out_temp == 32'd0, "R6 reset data", $signed(out_temp), 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1;
    check(out_valid == 1'b0, "R6 post-reset valid", int'(out_valid), 0);
    // Directed corners, back to back (R2, R4, R5)
    send(1'b1, 10'd0);
    send(1'b1, 10'd1023);
    send(1'b1, 10'd512);
    send(1'b1, 10'd1);
    // R7: gaps carrying junk codes
    send(1'b0, 10'd1023);
    send(1'b0, 10'd77);
    send(1'b1, 10'd0);
    send(1'b0, 10'd300);
    // Full sweep without gaps (R2, R3)
    for (int n = 0; n < 1024; n++) send(1'b1, 10'(n));
    // Random codes with random gaps (R3, R7, R8)
    for (int k = 0; k < 600; k++) send(($urandom % 3) != 0, 10'($urandom));
    send(1'b0, 10'd0);
    repeat (10) @(negedge clk);
    check(pend.size() == 0, "R1 all results delivered", pend.size(), 0);
    if (!done) done = 1;
    #1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(posedge done);
    if (cyc > 100000) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule